// File: doc/BRIEF.md
# Banked Register Address Pointer

This block keeps the internal byte address for a serial-bus slave whose memory space is split into banks: a thirteen-byte bank of timekeeping registers and two 256-byte data banks. A byte-level protocol engine tells the block which bank the slave address selected, whether a received byte is the word address or data, and when a byte has been read out. The block loads the pointer from the word address. It steps the pointer after every data byte. The step rule depends on the bank and on the direction of the transfer.

Reads from the timekeeping bank are served from a shadow copy of the live time values, so a running clock can tick during a long read without tearing it. The shadow copy is refreshed when a bus START is seen. It is also refreshed when the timekeeping pointer rolls over to address zero. Data-bank reads pass the storage array's data through. Writes leave through a single write enable with a bank-qualified address.

Top module: `mbp_addr_ptr`

## Requirements
- R1: After reset, `ptr` is 00h, `mem_we` and `snapshot_en` are low, and the timekeeping read data at address 00h is 00h. With no byte strobe, `ptr` holds its value.
- R2: A `wr_byte` with `is_addr_byte` high loads `wdata` into `ptr` at the next clock edge and keeps `mem_we` low in that cycle.
- R3: `snapshot_en` is high in any cycle where `start` is high. At that clock edge, all thirteen live time bytes (`live_time[8*i+7:8*i]` holds register i) are copied into the shadow bank.
- R4: In bank 0, a data-byte step from a pointer of 0Ch or above sets `ptr` to 00h. This applies to both reads and writes. In that same cycle `snapshot_en` is high, so the shadow bank is refreshed.
- R5: While `block_sel` is 0, `rd_data` is shadow byte `ptr` and does not follow the live inputs. For a pointer above 0Ch it is 00h. Writes to bank 0 leave the shadow bank unchanged.
- R6: A read step in bank 1 or 2 adds one to `ptr` modulo 256, so FFh is followed by 00h.
- R7: A data write in bank 1 or 2 raises `mem_we`. Address `mem_addr` equals {`block_sel`, `ptr`}, with the bank in bits [9:8]. `ptr[7:3]` is kept and `ptr[2:0]` steps modulo 8.
- R8: A data write in bank 0 raises `mem_we` with `mem_addr` = {2'b00, `ptr`}. The pointer then steps under the bank-0 rule.
- R9: `block_sel` = 3 is an invalid bank. It never raises `mem_we`, and `rd_data` is 00h. Its pointer steps by one modulo 256.
- R10: When `rd_byte` and a data `wr_byte` arrive in the same cycle, only the write is acted on, and the pointer steps once by the write rule.
- R11: While `block_sel` is 1 or 2, `rd_data` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse on a bus START condition |
| block_sel | input | 2 | Bank chosen by the slave address byte |
| rd_byte | input | 1 | A data byte has been read out |
| wr_byte | input | 1 | A byte has been received |
| is_addr_byte | input | 1 | The received byte is the word address |
| wdata | input | 8 | Received byte |
| live_time | input | 104 | Live timekeeping registers, byte i at bits 8i+7:8i |
| mem_rdata | input | 8 | Read data from the data-bank storage |
| ptr | output | 8 | Current byte pointer |
| snapshot_en | output | 1 | Shadow bank capture strobe |
| mem_we | output | 1 | Write enable for the byte at `mem_addr` |
| mem_addr | output | 10 | Bank-qualified address {block_sel, ptr} |
| rd_data | output | 8 | Byte to be returned to the bus |

## Verification
The hardest case to reach from the ports is showing that a pointer rollover refreshes the shadow bank mid-read, rather than only a START doing so. The bench captures one pattern with a START and then changes the live inputs. It reads up to register 0Ch and checks that the old pattern is still returned there. After the rollover it checks that the new pattern appears at address 00h. A bank-0 write with a distinctive value, followed by a read of the same address, shows the shadow bank was not written.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  // Bank codes as decoded from the slave address byte.
  typedef enum logic [1:0] {
    BLK_TIME  = 2'd0,
    BLK_DATA0 = 2'd1,
    BLK_DATA1 = 2'd2,
    BLK_NONE  = 2'd3
  } blk_e;

  // Byte-level operation presented by the protocol engine this cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_e;

endpackage

// File: rtl/mbp_op_decode.sv
module mbp_op_decode
  import mbp_pkg::*;
(
  input  logic rd_byte,
  input  logic wr_byte,
  input  logic is_addr_byte,
  output op_e  op
);

  // Write strobes take precedence over a coincident read strobe.
  always_comb begin
    op = OP_IDLE;
    if (wr_byte) begin
      op = is_addr_byte ? OP_LOAD : OP_WR;
    end else if (rd_byte) begin
      op = OP_RD;
    end
  end

endmodule

// File: rtl/mbp_ptr_step.sv
module mbp_ptr_step
  import mbp_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int TK_REGS   = 13,
  parameter int PAGE_BITS = 3
) (
  input  logic [PTR_W-1:0] ptr,
  input  blk_e             blk,
  input  logic             is_write,
  output logic [PTR_W-1:0] ptr_nxt,
  output logic             tk_wrap
);

  localparam logic [PTR_W-1:0] TK_LAST   = PTR_W'(TK_REGS - 1);
  localparam logic [PTR_W-1:0] PAGE_MASK = PTR_W'((1 << PAGE_BITS) - 1);
  localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_page;
  logic             is_data_blk;

  assign ptr_inc     = ptr + ONE;
  assign ptr_page    = (ptr & ~PAGE_MASK) | (ptr_inc & PAGE_MASK);
  assign is_data_blk = (blk == BLK_DATA0) || (blk == BLK_DATA1);

  always_comb begin
    tk_wrap = 1'b0;
    ptr_nxt = ptr_inc;
    if (blk == BLK_TIME) begin
      tk_wrap = (ptr >= TK_LAST);
      ptr_nxt = tk_wrap ? '0 : ptr_inc;
    end else if (is_data_blk && is_write) begin
      ptr_nxt = ptr_page;
    end
  end

endmodule

// File: rtl/mbp_shadow.sv
module mbp_shadow #(
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 8,
  parameter int TK_REGS = 13
) (
  input  logic                      clk,
  input  logic                      rst_i_n,
  input  logic                      capture,
  input  logic [TK_REGS*DATA_W-1:0] live_time,
  input  logic [PTR_W-1:0]          rd_idx,
  output logic [DATA_W-1:0]         rd_byte_q
);

  logic [DATA_W-1:0] sh_q [TK_REGS];

  for (genvar gi = 0; gi < TK_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        sh_q[gi] <= '0;
      end else if (capture) begin
        sh_q[gi] <= live_time[gi*DATA_W +: DATA_W];
      end
    end
  end

  // Indices past the last register read as zero.
  always_comb begin
    rd_byte_q = '0;
    for (int i = 0; i < TK_REGS; i++) begin
      if (rd_idx == PTR_W'(i)) begin
        rd_byte_q = sh_q[i];
      end
    end
  end

endmodule

// File: rtl/mbp_addr_ptr.sv
module mbp_addr_ptr
  import mbp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int BLK_W     = 2,
  parameter int TK_REGS   = 13,
  parameter int PAGE_BITS = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [BLK_W-1:0]          block_sel,
  input  logic                      rd_byte,
  input  logic                      wr_byte,
  input  logic                      is_addr_byte,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [TK_REGS*DATA_W-1:0] live_time,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic [PTR_W-1:0]          ptr,
  output logic                      snapshot_en,
  output logic                      mem_we,
  output logic [BLK_W+PTR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]         rd_data
);

  localparam int ADDR_W = BLK_W + PTR_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[SYNC_STG-1];

  blk_e             blk;
  op_e              op;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic [PTR_W-1:0] ptr_step;
  logic             tk_wrap;
  logic             step_now;
  logic [DATA_W-1:0] shadow_rd;

  assign blk = blk_e'(block_sel);

  mbp_op_decode u_dec (
    .rd_byte      (rd_byte),
    .wr_byte      (wr_byte),
    .is_addr_byte (is_addr_byte),
    .op           (op)
  );

  mbp_ptr_step #(
    .PTR_W     (PTR_W),
    .TK_REGS   (TK_REGS),
    .PAGE_BITS (PAGE_BITS)
  ) u_step (
    .ptr      (ptr_q),
    .blk      (blk),
    .is_write (op == OP_WR),
    .ptr_nxt  (ptr_step),
    .tk_wrap  (tk_wrap)
  );

  assign step_now    = (op == OP_WR) || (op == OP_RD);
  assign snapshot_en = start || (step_now && tk_wrap);

  mbp_shadow #(
    .DATA_W  (DATA_W),
    .PTR_W   (PTR_W),
    .TK_REGS (TK_REGS)
  ) u_shadow (
    .clk       (clk),
    .rst_i_n   (rst_i_n),
    .capture   (snapshot_en),
    .live_time (live_time),
    .rd_idx    (ptr_q),
    .rd_byte_q (shadow_rd)
  );

  // Pointer next-state.
  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    unique case (op)
      OP_LOAD: begin
        ptr_en = 1'b1;
        ptr_d  = PTR_W'(wdata);
      end
      OP_WR, OP_RD: begin
        ptr_en = 1'b1;
        ptr_d  = ptr_step;
      end
      default: begin
        ptr_en = 1'b0;
        ptr_d  = ptr_q;
      end
    endcase
  end

  // Pointer register.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr      = ptr_q;
  assign mem_addr = ADDR_W'({block_sel, ptr_q});
  assign mem_we   = (op == OP_WR) && (blk != BLK_NONE);

  always_comb begin
    unique case (blk)
      BLK_TIME:             rd_data = shadow_rd;
      BLK_DATA0, BLK_DATA1: rd_data = mem_rdata;
      default:              rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mbp_checker.sv
module mbp_checker #(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int BLK_W     = 2,
  parameter int TK_REGS   = 13,
  parameter int PAGE_BITS = 3
) (
  input logic                   clk,
  input logic                   rst_i_n,
  input logic                   start,
  input logic [BLK_W-1:0]       block_sel,
  input logic                   rd_byte,
  input logic                   wr_byte,
  input logic                   is_addr_byte,
  input logic [DATA_W-1:0]      wdata,
  input logic [PTR_W-1:0]       ptr,
  input logic                   snapshot_en,
  input logic                   mem_we,
  input logic [DATA_W-1:0]      rd_data
);

  localparam logic [PTR_W-1:0] TK_LAST = PTR_W'(TK_REGS - 1);

  logic data_blk;
  logic step_op;
  assign data_blk = (block_sel == BLK_W'(1)) || (block_sel == BLK_W'(2));
  assign step_op  = (wr_byte && !is_addr_byte) || (rd_byte && !wr_byte);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!rd_byte && !wr_byte) |=> $stable(ptr));

  a_r2_load_ptr: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_byte && is_addr_byte) |=> (ptr == PTR_W'($past(wdata))));

  a_r2_load_no_we: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_byte && is_addr_byte) |-> !mem_we);

  a_r3_start_snap: assert property (@(posedge clk) disable iff (!rst_i_n)
    start |-> snapshot_en);

  a_r4_tk_wrap: assert property (@(posedge clk) disable iff (!rst_i_n)
    (step_op && block_sel == '0 && ptr >= TK_LAST) |=> (ptr == '0));

  a_r4_wrap_snap: assert property (@(posedge clk) disable iff (!rst_i_n)
    (step_op && block_sel == '0 && ptr >= TK_LAST) |-> snapshot_en);

  a_r6_data_rd: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_byte && !wr_byte && data_blk) |=> (ptr == $past(ptr) + PTR_W'(1)));

  a_r7_page: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_byte && !is_addr_byte && data_blk) |=>
      ((ptr[PTR_W-1:PAGE_BITS] == $past(ptr[PTR_W-1:PAGE_BITS])) &&
       (ptr[PAGE_BITS-1:0] == $past(ptr[PAGE_BITS-1:0]) + PAGE_BITS'(1))));

  a_r9_bad_no_we: assert property (@(posedge clk) disable iff (!rst_i_n)
    (block_sel == '1) |-> !mem_we);

  a_r9_bad_rd: assert property (@(posedge clk) disable iff (!rst_i_n)
    (block_sel == '1) |-> (rd_data == '0));

endmodule

bind mbp_addr_ptr mbp_checker #(
  .DATA_W    (DATA_W),
  .PTR_W     (PTR_W),
  .BLK_W     (BLK_W),
  .TK_REGS   (TK_REGS),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk          (clk),
  .rst_i_n      (rst_i_n),
  .start        (start),
  .block_sel    (block_sel),
  .rd_byte      (rd_byte),
  .wr_byte      (wr_byte),
  .is_addr_byte (is_addr_byte),
  .wdata        (wdata),
  .ptr          (ptr),
  .snapshot_en  (snapshot_en),
  .mem_we       (mem_we),
  .rd_data      (rd_data)
);

// File: tb/mbp_addr_ptr_test.sv
module mbp_addr_ptr_test;

  localparam int NREG = 13;
  localparam int NVEC = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   block_sel = 2'd0;
  logic         rd_byte = 1'b0;
  logic         wr_byte = 1'b0;
  logic         is_addr_byte = 1'b0;
  logic [7:0]   wdata = 8'd0;
  logic [103:0] live_time = '0;
  logic [7:0]   mem_rdata = 8'd0;
  logic [7:0]   ptr;
  logic         snapshot_en;
  logic         mem_we;
  logic [9:0]   mem_addr;
  logic [7:0]   rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       o_we, o_snap;
  logic [9:0] o_addr;
  logic [7:0] o_rd;

  always #4 clk = ~clk;

  mbp_addr_ptr uut (
    .clk(clk), .rst_n(rst_n), .start(start), .block_sel(block_sel),
    .rd_byte(rd_byte), .wr_byte(wr_byte), .is_addr_byte(is_addr_byte),
    .wdata(wdata), .live_time(live_time), .mem_rdata(mem_rdata),
    .ptr(ptr), .snapshot_en(snapshot_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .rd_data(rd_data)
  );

  // kind: 0 load, 1 data write, 2 read | bank | byte | expected ptr | expected we
  localparam logic [20:0] TBL [0:NVEC-1] = '{
    {2'd0, 2'd1, 8'h3E, 8'h3E, 1'b0},
    {2'd1, 2'd1, 8'hAA, 8'h3F, 1'b1},
    {2'd1, 2'd1, 8'hBB, 8'h38, 1'b1},
    {2'd2, 2'd1, 8'h00, 8'h39, 1'b0},
    {2'd0, 2'd2, 8'hFE, 8'hFE, 1'b0},
    {2'd2, 2'd2, 8'h00, 8'hFF, 1'b0},
    {2'd2, 2'd2, 8'h00, 8'h00, 1'b0},
    {2'd0, 2'd0, 8'h0A, 8'h0A, 1'b0},
    {2'd1, 2'd0, 8'h11, 8'h0B, 1'b1},
    {2'd0, 2'd3, 8'hFF, 8'hFF, 1'b0},
    {2'd1, 2'd3, 8'h12, 8'h00, 1'b0},
    {2'd0, 2'd2, 8'hC7, 8'hC7, 1'b0},
    {2'd1, 2'd2, 8'h00, 8'hC0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind 3 = read and data write together
  task automatic op(input int kind, input logic [1:0] blk, input logic [7:0] dat);
    @(negedge clk);
    block_sel    = blk;
    wdata        = dat;
    wr_byte      = (kind == 0) || (kind == 1) || (kind == 3);
    is_addr_byte = (kind == 0);
    rd_byte      = (kind == 2) || (kind == 3);
    #1;
    o_we = mem_we; o_snap = snapshot_en; o_addr = mem_addr; o_rd = rd_data;
    @(posedge clk);
    #1;
    wr_byte = 1'b0; rd_byte = 1'b0; is_addr_byte = 1'b0;
    #1;
  endtask

  function automatic logic [103:0] pattern(input logic [7:0] base);
    logic [103:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(ptr == 8'h00, "R1 reset ptr", ptr, 0);
    check(!mem_we && !snapshot_en, "R1 reset strobes", {mem_we, snapshot_en}, 0);
    check(rd_data == 8'h00, "R1 reset shadow", rd_data, 0);
    repeat (2) @(negedge clk);
    #1;
    check(ptr == 8'h00, "R1 idle hold", ptr, 0);

    for (int v = 0; v < NVEC; v++) begin
      op(int'(TBL[v][20:19]), TBL[v][18:17], TBL[v][16:9]);
      check(o_we == TBL[v][0], "R2 R6 R7 R8 R9 vector we", o_we, TBL[v][0]);
      check(ptr == TBL[v][8:1], "R2 R6 R7 R8 R9 vector ptr", ptr, TBL[v][8:1]);
    end

    // R3: START captures pattern A, later live changes are not seen
    live_time = pattern(8'h10);
    @(negedge clk); start = 1'b1; #1; o_snap = snapshot_en;
    @(posedge clk); #1; start = 1'b0;
    check(o_snap, "R3 start snapshot", o_snap, 1);
    live_time = pattern(8'h80);
    op(0, 2'd0, 8'h03); #1;
    check(rd_data == 8'h13, "R5 shadow read", rd_data, 8'h13);
    op(0, 2'd0, 8'h0B);
    op(2, 2'd0, 8'h00);
    check(o_rd == 8'h1B && !o_snap, "R5 read 0Bh", o_rd, 8'h1B);
    op(2, 2'd0, 8'h00);
    check(o_rd == 8'h1C, "R5 read 0Ch", o_rd, 8'h1C);
    check(o_snap, "R4 wrap snapshot", o_snap, 1);
    check(ptr == 8'h00, "R4 wrap ptr", ptr, 0);
    #1;
    check(rd_data == 8'h80, "R4 new copy after wrap", rd_data, 8'h80);

    op(0, 2'd0, 8'h20); #1;
    check(rd_data == 8'h00, "R5 beyond last reads 0", rd_data, 0);
    op(1, 2'd0, 8'h55);
    check(o_snap && ptr == 8'h00, "R4 write wrap above 0Ch", ptr, 0);

    // R8 and R5: bank-0 write goes out, shadow unchanged
    op(0, 2'd0, 8'h02);
    op(1, 2'd0, 8'h77);
    check(o_we && o_addr == 10'h002, "R8 tk write addr", o_addr, 10'h002);
    check(ptr == 8'h03, "R8 tk write step", ptr, 3);
    op(0, 2'd0, 8'h02); #1;
    check(rd_data == 8'h82, "R5 shadow not written", rd_data, 8'h82);

    // R11 and R9 read data
    mem_rdata = 8'h5A;
    op(0, 2'd1, 8'h10); #1;
    check(rd_data == 8'h5A, "R11 data bank read", rd_data, 8'h5A);
    op(0, 2'd3, 8'h10); #1;
    check(rd_data == 8'h00, "R9 invalid bank read", rd_data, 0);
    op(2, 2'd3, 8'h00);
    check(ptr == 8'h11 && !o_we, "R9 invalid bank step", ptr, 8'h11);

    // R7 address on a bank-2 write
    op(0, 2'd2, 8'h41);
    op(1, 2'd2, 8'h99);
    check(o_we && o_addr == 10'h241, "R7 data write addr", o_addr, 10'h241);

    // R10 simultaneous read and write
    op(0, 2'd1, 8'h3F);
    op(3, 2'd1, 8'h66);
    check(o_we, "R10 write wins we", o_we, 1);
    check(ptr == 8'h38, "R10 single write step", ptr, 8'h38);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule